// File: doc/BRIEF.md
# Sector Program Capture Sequencer

This block sits behind the serial front end of a small nonvolatile memory. It takes the sampled serial bit stream of one chip-select frame and counts every bit from the opcode onward. It collects the target address and a whole sector of data bytes into a local buffer. When chip select rises, it judges from the exact bit count whether the frame ended at the one legal point for its opcode. A legal frame also needs the permit from the protection unit. When both hold, the block raises a busy flag for a self-timed interval, then writes the sector into the array one byte per cycle, and finally pulses a completion strobe. The completion strobe is what clears the program-enable latch held elsewhere.

A status-register program frame is handled the same way, with a single data byte in place of the sector. A frame that ends at any other bit count is dropped with no effect and no report, and so is a frame the protection unit refuses. While the busy flag is high, new frames are neither captured nor committed.

Top module: `psq_top`

## Requirements
- R1: Out of reset, and after a reset applied while a program is pending, `pip`, `done`, `arr_we` and `sr_we` are all 0 and no write follows.
- R2: An array frame commits when its opcode is 0x02, it carries 16 address bits MSB first and then exactly 32 data bytes, it ends after exactly 280 bits, and `arr_permit` is 1 at the frame end. The commit then writes all 32 bytes of the addressed sector, starting at the sector base offset 0 and in ascending address order.
- R3: Data byte k of a frame lands at sector offset (start offset + k) mod 32, so a start address inside a sector wraps around within that same sector.
- R4: An array frame that ends after any bit count other than 280 causes no write, no busy interval and no `done`.
- R5: A status frame (opcode 0x01 followed by one data byte) commits only when it ends after exactly 16 bits with `sr_permit` at 1. It produces one `sr_we` pulse carrying that byte. Any other length of status frame has no effect.
- R6: A frame of legal length ends with no effect when its permit input is 0 at the frame end.
- R7: `pip` rises the cycle after a committing frame end and stays high for exactly BUSY_CYC cycles before the first write, and it also stays high through the last write. `done` is a one-cycle pulse in the cycle after the last write, and `pip` is 0 in that cycle.
- R8: A frame received while `pip` is high changes neither the buffered data nor the captured address, and it starts no second program.
- R9: A frame with any other opcode, such as 0x03, never starts a program, even when it ends after exactly 280 bits.
- R10: `prog_sector` shows the sector bits (address bits 7:5 with the default parameters) of the address most recently received while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | One serial bit is present on `bit_in` this cycle |
| bit_in | input | 1 | Serial data bit, MSB first |
| frame_end | input | 1 | One-cycle pulse at chip-select rise |
| arr_permit | input | 1 | Protection unit allows programming of `prog_sector` |
| sr_permit | input | 1 | Protection unit allows a status-register program |
| pip | output | 1 | Program cycle in progress |
| prog_sector | output | ADDR_W-log2(SECT_BYTES) | Sector of the captured address |
| arr_we | output | 1 | Array byte write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data |
| sr_we | output | 1 | Status register write strobe |
| sr_wdata | output | 8 | Status register write data |
| done | output | 1 | Program cycle complete, one cycle |

## Verification
Most faults in the bit counter or the length decode show up at the very next frame end. Either a legal frame raises no `pip`, or an illegal length raises `pip` one cycle after `frame_end`. A wrong buffer index or wrong start offset shows up only once the busy interval has elapsed, as a wrong byte on `arr_wdata` at a given `arr_addr`. A timer or write-counter fault shifts the first write or the `done` pulse by some cycles, which the count of busy cycles before the first write exposes. A capture gate that stays open during busy shows up as changed data, or as a changed `prog_sector`, in the writes of the program already pending.

// File: rtl/psq_pkg.sv
package psq_pkg;
  localparam logic [7:0] OP_ARRAY_PROG  = 8'h02;
  localparam logic [7:0] OP_STATUS_PROG = 8'h01;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_WRITE = 2'd2
  } seq_st_e;
endpackage

// File: rtl/psq_deser.sv
// Counts frame bits (saturating) and assembles whole bytes, MSB first.
module psq_deser #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic             frame_end,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             byte_vld,
  output logic [7:0]       byte_val,
  output logic [CNT_W-4:0] byte_num
);
  localparam logic [CNT_W-1:0] CNT_SAT = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [6:0]       sh_q, sh_d;
  logic             bv_d;
  logic [7:0]       bval_d;
  logic [CNT_W-4:0] bnum_d;

  always_comb begin
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    bv_d   = 1'b0;
    bval_d = byte_val;
    bnum_d = byte_num;
    if (frame_end) begin
      cnt_d = '0;
    end else if (bit_vld) begin
      sh_d = {sh_q[5:0], bit_in};
      if (cnt_q != CNT_SAT) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q[2:0] == 3'd7) begin
          bv_d   = 1'b1;
          bval_d = {sh_q, bit_in};
          bnum_d = cnt_q[CNT_W-1:3];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      sh_q     <= '0;
      byte_vld <= 1'b0;
      byte_val <= '0;
      byte_num <= '0;
    end else begin
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      byte_vld <= bv_d;
      byte_val <= bval_d;
      byte_num <= bnum_d;
    end
  end

  assign bit_cnt = cnt_q;
endmodule

// File: rtl/psq_sbuf.sv
// Sector staging buffer: one write port, one combinational read port.
// Storage carries no reset; every entry is rewritten before a commit reads it.
module psq_sbuf #(
  parameter int DEPTH = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);
  logic [7:0] ent_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [7:0] ent_q;
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(g))) ent_q <= wr_data;
    end
    assign ent_w[g] = ent_q;
  end

  assign rd_data = ent_w[rd_idx];
endmodule

// File: rtl/psq_ctrl.sv
// Frame decode, length/permit judgement at frame end, busy timer, write-out.
module psq_ctrl
  import psq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int OFF_W      = 5,
  parameter int SECT_BYTES = 32,
  parameter int ABYTES     = 2,
  parameter int CNT_W      = 9,
  parameter int FRAME_BITS = 280,
  parameter int SR_BITS    = 16,
  parameter int BUSY_CYC   = 1000,
  parameter int TMR_W      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic              byte_vld,
  input  logic [7:0]        byte_val,
  input  logic [CNT_W-4:0]  byte_num,
  input  logic              frame_end,
  input  logic              arr_permit,
  input  logic              sr_permit,
  output logic              buf_we,
  output logic [OFF_W-1:0]  buf_widx,
  output logic [OFF_W-1:0]  rd_idx,
  output logic              pip,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              sr_we,
  output logic [7:0]        sr_wdata,
  output logic              done,
  output logic [ADDR_W-OFF_W-1:0] prog_sector
);
  localparam int BN_W = CNT_W - 3;
  localparam logic [CNT_W-1:0] ARR_LEN  = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] SR_LEN   = CNT_W'(SR_BITS);
  localparam logic [BN_W-1:0]  AB_LAST  = BN_W'(ABYTES);
  localparam logic [BN_W-1:0]  DB_FIRST = BN_W'(ABYTES + 1);
  localparam logic [BN_W-1:0]  DB_END   = BN_W'(ABYTES + 1 + SECT_BYTES);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(BUSY_CYC - 1);
  localparam logic [OFF_W-1:0] W_LAST   = OFF_W'(SECT_BYTES - 1);

  seq_st_e           st_q, st_d;
  logic [7:0]        op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        srd_q, srd_d;
  logic              kind_q, kind_d;    // 1: array program, 0: status program
  logic              taint_q, taint_d;  // frame had bytes arrive while busy
  logic [TMR_W-1:0]  tmr_q, tmr_d;
  logic [OFF_W-1:0]  wcnt_q, wcnt_d;
  logic              done_d;
  logic              cap;

  // Capture path: gated by idle state (R8).
  assign cap      = byte_vld && (st_q == ST_IDLE);
  assign buf_we   = cap && (byte_num >= DB_FIRST) && (byte_num < DB_END);
  assign buf_widx = addr_q[OFF_W-1:0] + OFF_W'(byte_num - DB_FIRST);  // R3 wrap

  always_comb begin
    op_d    = op_q;
    addr_d  = addr_q;
    srd_d   = srd_q;
    taint_d = taint_q;
    if (cap && (byte_num == '0)) op_d = byte_val;
    if (cap && (byte_num != '0) && (byte_num <= AB_LAST))
      addr_d = ADDR_W'({addr_q, byte_val});
    if (cap && (byte_num == BN_W'(1))) srd_d = byte_val;
    if (frame_end) taint_d = 1'b0;
    else if (byte_vld && (st_q != ST_IDLE)) taint_d = 1'b1;
  end

  // Sequencer next state.
  always_comb begin
    st_d   = st_q;
    kind_d = kind_q;
    tmr_d  = tmr_q;
    wcnt_d = wcnt_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (frame_end && !taint_q) begin
          if ((op_q == OP_ARRAY_PROG) && (bit_cnt == ARR_LEN) && arr_permit) begin
            st_d   = ST_BUSY;
            kind_d = 1'b1;
            tmr_d  = '0;
          end else if ((op_q == OP_STATUS_PROG) && (bit_cnt == SR_LEN) && sr_permit) begin
            st_d   = ST_BUSY;
            kind_d = 1'b0;
            tmr_d  = '0;
          end
        end
      end
      ST_BUSY: begin
        tmr_d = tmr_q + 1'b1;
        if (tmr_q == TMR_LAST) begin
          st_d   = ST_WRITE;
          wcnt_d = '0;
        end
      end
      ST_WRITE: begin
        wcnt_d = wcnt_q + 1'b1;
        if (!kind_q || (wcnt_q == W_LAST)) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      op_q    <= '0;
      addr_q  <= '0;
      srd_q   <= '0;
      kind_q  <= 1'b0;
      taint_q <= 1'b0;
      tmr_q   <= '0;
      wcnt_q  <= '0;
      done    <= 1'b0;
    end else begin
      st_q    <= st_d;
      op_q    <= op_d;
      addr_q  <= addr_d;
      srd_q   <= srd_d;
      kind_q  <= kind_d;
      taint_q <= taint_d;
      tmr_q   <= tmr_d;
      wcnt_q  <= wcnt_d;
      done    <= done_d;
    end
  end

  assign pip         = (st_q != ST_IDLE);
  assign arr_we      = (st_q == ST_WRITE) && kind_q;
  assign sr_we       = (st_q == ST_WRITE) && !kind_q;
  assign arr_addr    = {addr_q[ADDR_W-1:OFF_W], wcnt_q};
  assign rd_idx      = wcnt_q;
  assign sr_wdata    = srd_q;
  assign prog_sector = addr_q[ADDR_W-1:OFF_W];
endmodule

// File: rtl/psq_top.sv
module psq_top #(
  parameter int ADDR_W         = 8,
  parameter int SECT_BYTES     = 32,
  parameter int WIRE_ADDR_BITS = 16,
  parameter int BUSY_CYC       = 500000
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   bit_vld,
  input  logic                                   bit_in,
  input  logic                                   frame_end,
  input  logic                                   arr_permit,
  input  logic                                   sr_permit,
  output logic                                   pip,
  output logic [ADDR_W-$clog2(SECT_BYTES)-1:0]   prog_sector,
  output logic                                   arr_we,
  output logic [ADDR_W-1:0]                      arr_addr,
  output logic [7:0]                             arr_wdata,
  output logic                                   sr_we,
  output logic [7:0]                             sr_wdata,
  output logic                                   done
);
  localparam int OFF_W      = $clog2(SECT_BYTES);
  localparam int ABYTES     = WIRE_ADDR_BITS / 8;
  localparam int FRAME_BITS = 8 * (1 + ABYTES + SECT_BYTES);
  localparam int SR_BITS    = 16;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);
  localparam int TMR_W      = $clog2(BUSY_CYC + 1);

  logic [CNT_W-1:0] bit_cnt;
  logic             byte_vld;
  logic [7:0]       byte_val;
  logic [CNT_W-4:0] byte_num;
  logic             buf_we;
  logic [OFF_W-1:0] buf_widx;
  logic [OFF_W-1:0] rd_idx;

  psq_deser #(.CNT_W(CNT_W)) u_deser (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_vld   (bit_vld),
    .bit_in    (bit_in),
    .frame_end (frame_end),
    .bit_cnt   (bit_cnt),
    .byte_vld  (byte_vld),
    .byte_val  (byte_val),
    .byte_num  (byte_num)
  );

  psq_sbuf #(.DEPTH(SECT_BYTES), .IDX_W(OFF_W)) u_sbuf (
    .clk     (clk),
    .wr_en   (buf_we),
    .wr_idx  (buf_widx),
    .wr_data (byte_val),
    .rd_idx  (rd_idx),
    .rd_data (arr_wdata)
  );

  psq_ctrl #(
    .ADDR_W     (ADDR_W),
    .OFF_W      (OFF_W),
    .SECT_BYTES (SECT_BYTES),
    .ABYTES     (ABYTES),
    .CNT_W      (CNT_W),
    .FRAME_BITS (FRAME_BITS),
    .SR_BITS    (SR_BITS),
    .BUSY_CYC   (BUSY_CYC),
    .TMR_W      (TMR_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_cnt     (bit_cnt),
    .byte_vld    (byte_vld),
    .byte_val    (byte_val),
    .byte_num    (byte_num),
    .frame_end   (frame_end),
    .arr_permit  (arr_permit),
    .sr_permit   (sr_permit),
    .buf_we      (buf_we),
    .buf_widx    (buf_widx),
    .rd_idx      (rd_idx),
    .pip         (pip),
    .arr_we      (arr_we),
    .arr_addr    (arr_addr),
    .sr_we       (sr_we),
    .sr_wdata    (sr_wdata),
    .done        (done),
    .prog_sector (prog_sector)
  );
endmodule

// File: rtl/psq_chk.sv
module psq_chk #(
  parameter int ADDR_W   = 8,
  parameter int OFF_W    = 5,
  parameter int BUSY_CYC = 1000
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    pip,
  input logic                    arr_we,
  input logic [ADDR_W-1:0]       arr_addr,
  input logic                    sr_we,
  input logic                    done,
  input logic [ADDR_W-OFF_W-1:0] prog_sector
);
  logic [31:0] pip_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pip_run_q <= '0;
    else if (!pip) pip_run_q <= '0;
    else if (pip_run_q != 32'hFFFF_FFFF) pip_run_q <= pip_run_q + 1'b1;
  end

  p_busy_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we || sr_we) |-> (pip_run_q >= 32'(BUSY_CYC)));

  p_write_under_pip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we || sr_we) |-> pip);

  p_single_port_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_we && sr_we));

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |-> (arr_addr == $past(arr_addr) + 1'b1));

  p_first_at_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && !$past(arr_we)) |-> (arr_addr[OFF_W-1:0] == '0));

  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!pip && $past(pip)));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_sector_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pip && $past(pip)) |-> $stable(prog_sector));
endmodule

bind psq_top psq_chk #(
  .ADDR_W   (ADDR_W),
  .OFF_W    ($clog2(SECT_BYTES)),
  .BUSY_CYC (BUSY_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pip         (pip),
  .arr_we      (arr_we),
  .arr_addr    (arr_addr),
  .sr_we       (sr_we),
  .done        (done),
  .prog_sector (prog_sector)
);

// File: tb/tb_psq_top.sv
module tb_psq_top;
  localparam int BUSY = 700;
  localparam int NV   = 13;
  // {opcode[7:0], address[15:0], bit count[9:0], permit, commit expected}
  localparam logic [35:0] VECS [NV] = '{
    {8'h02, 16'h0040, 10'd280, 1'b1, 1'b1},
    {8'h02, 16'h00E7, 10'd280, 1'b1, 1'b1},
    {8'h02, 16'h0020, 10'd279, 1'b1, 1'b0},
    {8'h02, 16'h0020, 10'd281, 1'b1, 1'b0},
    {8'h02, 16'h0020, 10'd272, 1'b1, 1'b0},
    {8'h02, 16'h0060, 10'd280, 1'b0, 1'b0},
    {8'h01, 16'h8C00, 10'd16,  1'b1, 1'b1},
    {8'h01, 16'h8C00, 10'd15,  1'b1, 1'b0},
    {8'h01, 16'h8C00, 10'd24,  1'b1, 1'b0},
    {8'h03, 16'h0000, 10'd280, 1'b1, 1'b0},
    {8'h01, 16'h5A00, 10'd16,  1'b0, 1'b0},
    {8'h02, 16'h1F13, 10'd280, 1'b1, 1'b1},
    {8'h02, 16'h0000, 10'd0,   1'b1, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n, bit_vld, bit_in, frame_end, arr_permit, sr_permit;
  logic       pip, arr_we, sr_we, done;
  logic [2:0] prog_sector;
  logic [7:0] arr_addr, arr_wdata, sr_wdata;

  always #5 clk = ~clk;

  psq_top #(.BUSY_CYC(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .frame_end(frame_end), .arr_permit(arr_permit), .sr_permit(sr_permit),
    .pip(pip), .prog_sector(prog_sector), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .sr_we(sr_we), .sr_wdata(sr_wdata), .done(done)
  );

  int n_checks = 0, n_fail = 0;
  int n_arr = 0, n_sr = 0, n_done = 0, pcnt = 0, widx = 0;
  bit prev_we = 1'b0, finished = 1'b0;
  logic [7:0] exp_mem [32];
  logic [2:0] exp_sec;
  logic [7:0] exp_sr;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dbyte(input int seed, input int k);
    return 8'(seed * 37 + k * 11 + 5);
  endfunction

  function automatic logic sbit(input logic [7:0] op, input logic [15:0] a,
                                input int seed, input int i);
    logic [7:0] d;
    if (i < 8) return op[7-i];
    if (i < 24) return a[15-(i-8)];
    d = dbyte(seed, (i - 24) / 8);
    return d[7 - ((i - 24) % 8)];
  endfunction

  task automatic set_expect(input logic [15:0] a, input int seed);
    exp_sec = a[7:5];
    exp_sr  = a[15:8];
    for (int k = 0; k < 32; k++) exp_mem[5'(a[4:0] + k)] = dbyte(seed, k);
  endtask

  task automatic send_frame(input logic [7:0] op, input logic [15:0] a,
                            input int nb, input int seed);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk); bit_vld = 1'b1; bit_in = sbit(op, a, seed, i);
      @(negedge clk); bit_vld = 1'b0;
    end
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
  endtask

  // Port monitor: data, address order and busy length of every write.
  always @(negedge clk) begin
    if (!rst_n) begin
      pcnt = 0; prev_we = 1'b0; widx = 0;
    end else begin
      if ((arr_we || sr_we) && !prev_we) begin
        chk(pcnt == BUSY, "R7 busy cycles before first write", pcnt, BUSY);
        widx = 0;
      end
      if (arr_we) begin
        n_arr++;
        chk(arr_addr[7:5] == exp_sec, "R2 write sector", arr_addr[7:5], exp_sec);
        chk(arr_addr[4:0] == 5'(widx), "R2 ascending offset", arr_addr[4:0], widx);
        chk(arr_wdata == exp_mem[arr_addr[4:0]], "R3 byte placement",
            arr_wdata, exp_mem[arr_addr[4:0]]);
        widx++;
      end
      if (sr_we) begin
        n_sr++;
        chk(sr_wdata == exp_sr, "R5 status data", sr_wdata, exp_sr);
      end
      if (done) begin
        n_done++;
        chk(!pip && prev_we, "R7 done after last write", {pip, prev_we}, 1);
      end
      pcnt    = pip ? pcnt + 1 : 0;
      prev_we = arr_we || sr_we;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int a0, s0, d0;
    rst_n = 1'b0; bit_vld = 1'b0; bit_in = 1'b0; frame_end = 1'b0;
    arr_permit = 1'b0; sr_permit = 1'b0;
    repeat (3) @(negedge clk);
    chk(!pip && !done && !arr_we && !sr_we, "R1 reset outputs",
        {pip, done, arr_we, sr_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pip && !done, "R1 after release", {pip, done}, 0);

    // Table walk.
    for (int i = 0; i < NV; i++) begin
      logic [35:0] v;
      logic [7:0]  op;
      logic [15:0] ad;
      int          nb;
      bit          pm, cm;
      string       tag;
      v = VECS[i];
      op = v[35:28]; ad = v[27:12]; nb = int'(v[11:2]); pm = v[1]; cm = v[0];
      if (cm) tag = (op == 8'h02) ? "R2" : "R5";
      else if (!pm) tag = "R6";
      else if (op == 8'h03) tag = "R9";
      else if (op == 8'h01) tag = "R5";
      else tag = "R4";
      set_expect(ad, i + 1);
      arr_permit = pm; sr_permit = pm;
      a0 = n_arr; s0 = n_sr; d0 = n_done;
      send_frame(op, ad, nb, i + 1);
      repeat (BUSY + 60) @(negedge clk);
      chk((n_arr - a0) == ((cm && op == 8'h02) ? 32 : 0), {tag, " array writes"},
          n_arr - a0, (cm && op == 8'h02) ? 32 : 0);
      chk((n_sr - s0) == ((cm && op == 8'h01) ? 1 : 0), {tag, " status writes"},
          n_sr - s0, (cm && op == 8'h01) ? 1 : 0);
      chk((n_done - d0) == (cm ? 1 : 0), {tag, " done count"}, n_done - d0, cm ? 1 : 0);
      chk(!pip, {tag, " pip idle"}, pip, 0);
      if (nb >= 24) chk(prog_sector == ad[7:5], "R10 sector output", prog_sector, ad[7:5]);
    end

    // R8: a frame arriving during busy must not disturb the pending program.
    arr_permit = 1'b1; sr_permit = 1'b1;
    set_expect(16'h00A3, 40);
    a0 = n_arr; d0 = n_done;
    send_frame(8'h02, 16'h00A3, 280, 40);
    send_frame(8'h02, 16'h0040, 280, 41);
    chk(pip, "R8 still busy after second frame", pip, 1);
    repeat (BUSY + 60) @(negedge clk);
    chk((n_arr - a0) == 32, "R8 single commit writes", n_arr - a0, 32);
    chk((n_done - d0) == 1, "R8 single done", n_done - d0, 1);
    chk(prog_sector == 3'd5, "R8 sector kept", prog_sector, 5);

    // R1: reset during busy abandons the program.
    a0 = n_arr; d0 = n_done;
    send_frame(8'h02, 16'h0080, 280, 50);
    repeat (10) @(negedge clk);
    chk(pip, "R1 busy before reset", pip, 1);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!pip && !done && !arr_we, "R1 reset mid-busy", {pip, done, arr_we}, 0);
    rst_n = 1'b1;
    repeat (BUSY + 60) @(negedge clk);
    chk((n_arr - a0) == 0 && (n_done - d0) == 0, "R1 no write after reset",
        n_arr - a0, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule